// File: doc/BRIEF.md
# Pixel Packing Shift-Down Output Queue

This block sits between the pixel generator and the panel data pins of a display controller. Pixel data arrives one beat at a time over a valid/ready handshake and is collected in a small packing shifter. When a complete pin-width group has been assembled, it is written into one or both of two byte-wide queues of 16 entries each.

The queues use physical shift-down storage: every entry carries its own valid bit. A new entry goes to the lowest free position, and each pop moves all remaining entries one place toward the bottom. A mode input selects the pin width:

- **4-pin mode:** two nibbles share a byte.
- **8-pin mode:** each beat is one byte.
- **16-pin mode:** two beats form a 16-bit word split across both queues.

A pop strobe moves the bottom entry onto a registered output bus. Full and empty flags and a sticky underflow flag report the state of the queues. The mode is expected to change only while the queues are empty and the packer sits between groups.

Top module: `pxq_pack_fifo`

## Requirements
- R1: After reset, `empty` is 2'b11, `full` is 2'b00, `underflow` is 0, `dout` is 0 and `px_ready` is 1.
- R2: With `mode` 2'b01 (8-pin) or 2'b11 (reserved, same as 8-pin), every accepted beat writes `px_data` as one entry of queue 0. Pops return the entries in arrival order on `dout[7:0]`, with `dout[15:8]` at 0, in the cycle after the pop strobe.
- R3: With `mode` 2'b00 (4-pin), two accepted beats make one entry of queue 0. Bits [3:0] of the first beat land in entry bits [3:0], and bits [3:0] of the second beat land in bits [7:4]. Bits [7:4] of `px_data` are ignored. A single beat writes nothing.
- R4: With `mode` 2'b10 (16-pin), two accepted beats write the first byte to queue 0 and the second byte to queue 1 in the same cycle. One pop removes from both queues and shows {second, first} on `dout`.
- R5: Each queue holds 16 entries. `px_ready` is low while a target queue is full, and a beat offered while `px_ready` is low is not stored.
- R6: A write and a pop in the same cycle keep arrival order. The new entry lands one position lower than it would without the pop.
- R7: A pop while the source queue is empty leaves `dout` unchanged and sets `underflow`, which then stays at 1 until reset.
- R8: `empty[k]` is 1 exactly when queue k holds no entry, and `full[k]` is 1 exactly when it holds 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Pin width: 00 = 4-pin, 01 = 8-pin, 10 = 16-pin, 11 = 8-pin |
| px_valid | input | 1 | Pixel beat offered |
| px_ready | output | 1 | Beat can be accepted |
| px_data | input | 8 | Pixel beat data |
| pop | input | 1 | Output strobe: remove the bottom entry |
| dout | output | 16 | Registered pin data |
| full | output | 2 | Per-queue full flags |
| empty | output | 2 | Per-queue empty flags |
| underflow | output | 1 | Sticky: a pop found the queue empty |

## Verification
The bench fills a queue to exactly 16 entries and holds a beat on the input while it is full. A design that accepted that beat would return an extra value, or would lose the oldest value, when the queue is drained. It overlaps a write with a pop. A design that did not lower the write slot would leave a gap or overwrite the entry below. It also checks nibble order in 4-pin mode and byte order across the two queues in 16-pin mode, where a swapped packer shows mirrored data. Finally it pops an empty queue and then a non-empty one: a design that does not hold `dout` or does not latch `underflow` differs at the first of those pops.

// File: rtl/pxq_pkg.sv
package pxq_pkg;
   typedef enum logic [1:0] {
      PXQ_PIN4  = 2'b00,
      PXQ_PIN8  = 2'b01,
      PXQ_PIN16 = 2'b10,
      PXQ_RSVD  = 2'b11
   } pin_mode_e;
endpackage

// File: rtl/pxq_packer.sv
// Gathers serial beats into complete pin-width groups and emits queue writes.
module pxq_packer
   import pxq_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pin_mode_e         mode,
   input  logic              take,
   input  logic [BYTE_W-1:0] px_data,
   output logic              wr_lo,
   output logic              wr_hi,
   output logic [BYTE_W-1:0] wdata_lo,
   output logic [BYTE_W-1:0] wdata_hi
);
   localparam int NIB_W = BYTE_W / 2;

   logic              phase;   // 1: first half of a group is held
   logic [BYTE_W-1:0] hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= 1'b0;
         hold  <= '0;
      end else if (take && (mode == PXQ_PIN4 || mode == PXQ_PIN16)) begin
         phase <= ~phase;
         if (!phase) hold <= px_data;
      end
   end

   always_comb begin
      wr_lo    = 1'b0;
      wr_hi    = 1'b0;
      wdata_lo = px_data;
      wdata_hi = px_data;
      case (mode)
         PXQ_PIN4: begin
            wr_lo    = take && phase;
            wdata_lo = {px_data[NIB_W-1:0], hold[NIB_W-1:0]};
         end
         PXQ_PIN16: begin
            wr_lo    = take && phase;
            wr_hi    = take && phase;
            wdata_lo = hold;
         end
         default: wr_lo = take;
      endcase
   end
endmodule

// File: rtl/pxq_shift_queue.sv
// Shift-down queue: per-entry valid bits, write to lowest free slot.
module pxq_shift_queue #(
   parameter int DEPTH = 16,
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] push_data,
   input  logic             pop,       // only asserted when not empty
   output logic [WIDTH-1:0] head,
   output logic             full,
   output logic             empty
);
   logic [WIDTH-1:0] mem    [DEPTH];
   logic [WIDTH-1:0] sh_m   [DEPTH];
   logic [WIDTH-1:0] nx_m   [DEPTH];
   logic [DEPTH-1:0] vld, sh_v, nx_v;

   always_comb begin
      // step 1: optional shift down by one
      sh_v = pop ? {1'b0, vld[DEPTH-1:1]} : vld;
      for (int i = 0; i < DEPTH - 1; i++)
         sh_m[i] = pop ? mem[i+1] : mem[i];
      sh_m[DEPTH-1] = pop ? '0 : mem[DEPTH-1];
      // step 2: place the new entry in the lowest free slot
      nx_v = sh_v;
      nx_m = sh_m;
      if (push && !sh_v[0]) begin
         nx_v[0] = 1'b1;
         nx_m[0] = push_data;
      end
      for (int i = 1; i < DEPTH; i++) begin
         if (push && !sh_v[i] && sh_v[i-1]) begin
            nx_v[i] = 1'b1;
            nx_m[i] = push_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= '0;
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else begin
         vld <= nx_v;
         for (int i = 0; i < DEPTH; i++) mem[i] <= nx_m[i];
      end
   end

   assign head  = mem[0];
   assign full  = vld[DEPTH-1];
   assign empty = !vld[0];
endmodule

// File: rtl/pxq_pack_fifo.sv
module pxq_pack_fifo
   import pxq_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [1:0]          mode,
   input  logic                px_valid,
   output logic                px_ready,
   input  logic [BYTE_W-1:0]   px_data,
   input  logic                pop,
   output logic [2*BYTE_W-1:0] dout,
   output logic [1:0]          full,
   output logic [1:0]          empty,
   output logic                underflow
);
   localparam int N_Q   = 2;
   localparam int OUT_W = N_Q * BYTE_W;

   if (DEPTH < 2) begin : g_bad_depth
      $error("pxq_pack_fifo: DEPTH must be at least 2");
   end
   if (BYTE_W < 2 || (BYTE_W % 2) != 0) begin : g_bad_width
      $error("pxq_pack_fifo: BYTE_W must be even and at least 2");
   end

   pin_mode_e         mode_e;
   logic              wide, take, can_pop, do_pop;
   logic [N_Q-1:0]    q_push, q_pop, q_full, q_empty;
   logic [BYTE_W-1:0] q_wdata [N_Q];
   logic [BYTE_W-1:0] q_head  [N_Q];

   assign mode_e   = pin_mode_e'(mode);
   assign wide     = (mode_e == PXQ_PIN16);
   assign px_ready = wide ? !(q_full[0] || q_full[1]) : !q_full[0];
   assign take     = px_valid && px_ready;
   assign can_pop  = wide ? (!q_empty[0] && !q_empty[1]) : !q_empty[0];
   assign do_pop   = pop && can_pop;
   assign q_pop    = {do_pop && wide, do_pop};

   pxq_packer #(.BYTE_W(BYTE_W)) u_packer (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode_e),
      .take     (take),
      .px_data  (px_data),
      .wr_lo    (q_push[0]),
      .wr_hi    (q_push[1]),
      .wdata_lo (q_wdata[0]),
      .wdata_hi (q_wdata[1])
   );

   for (genvar k = 0; k < N_Q; k++) begin : g_q
      pxq_shift_queue #(.DEPTH(DEPTH), .WIDTH(BYTE_W)) u_q (
         .clk       (clk),
         .rst_n     (rst_n),
         .push      (q_push[k]),
         .push_data (q_wdata[k]),
         .pop       (q_pop[k]),
         .head      (q_head[k]),
         .full      (q_full[k]),
         .empty     (q_empty[k])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout      <= '0;
         underflow <= 1'b0;
      end else begin
         if (do_pop)
            dout <= wide ? {q_head[1], q_head[0]} : {{(OUT_W-BYTE_W){1'b0}}, q_head[0]};
         if (pop && !can_pop)
            underflow <= 1'b1;
      end
   end

   assign full  = q_full;
   assign empty = q_empty;
endmodule

// File: rtl/pxq_pack_fifo_chk.sv
module pxq_pack_fifo_chk #(
   parameter int BYTE_W = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic [1:0]          mode,
   input logic                px_ready,
   input logic                pop,
   input logic [2*BYTE_W-1:0] dout,
   input logic [1:0]          full,
   input logic [1:0]          empty,
   input logic                underflow
);
   logic narrow;
   assign narrow = (mode != 2'b10);

   a_r5_no_ready_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      (narrow && full[0]) |-> !px_ready);

   a_r7_underflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> underflow);

   a_r7_empty_pop_holds_dout: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && narrow && empty[0]) |=> $stable(dout));

   a_r8_flags_consistent: assert property (@(posedge clk) disable iff (!rst_n)
      !(full[0] && empty[0]) && !(full[1] && empty[1]));

   a_r2_narrow_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && narrow && !empty[0]) |=> (dout[2*BYTE_W-1:BYTE_W] == '0));
endmodule

bind pxq_pack_fifo pxq_pack_fifo_chk #(.BYTE_W(BYTE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mode      (mode),
   .px_ready  (px_ready),
   .pop       (pop),
   .dout      (dout),
   .full      (full),
   .empty     (empty),
   .underflow (underflow)
);

// File: tb/pxq_pack_fifo_tb.sv
`timescale 1ns/1ps
module pxq_pack_fifo_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode = 2'b01;
   logic        px_valid = 1'b0;
   logic        px_ready;
   logic [7:0]  px_data = '0;
   logic        pop = 1'b0;
   logic [15:0] dout;
   logic [1:0]  full, empty;
   logic        underflow;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   pxq_pack_fifo u_dut (
      .clk(clk), .rst_n(rst_n), .mode(mode), .px_valid(px_valid),
      .px_ready(px_ready), .px_data(px_data), .pop(pop), .dout(dout),
      .full(full), .empty(empty), .underflow(underflow)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] d);
      px_valid = 1'b1;
      px_data  = d;
      @(posedge clk); #1;
      px_valid = 1'b0;
   endtask

   task automatic pop_one();
      pop = 1'b1;
      @(posedge clk); #1;
      pop = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 empty", 16'(empty), 16'h3);
      chk("R1 full", 16'(full), 16'h0);
      chk("R1 underflow", 16'(underflow), 16'h0);
      chk("R1 dout", dout, 16'h0);
      chk("R1 ready", 16'(px_ready), 16'h1);
   endtask

   task automatic t_mode8();
      mode = 2'b01;
      push(8'hA5); push(8'h3C); push(8'h7E);
      chk("R8 not empty", 16'(empty[0]), 16'h0);
      pop_one(); chk("R2 pop0", dout, 16'h00A5);
      pop_one(); chk("R2 pop1", dout, 16'h003C);
      pop_one(); chk("R2 pop2", dout, 16'h007E);
      chk("R8 empty again", 16'(empty[0]), 16'h1);
      mode = 2'b11;
      push(8'h96);
      pop_one(); chk("R2 reserved mode", dout, 16'h0096);
   endtask

   task automatic t_mode4();
      mode = 2'b00;
      push(8'hF1);
      chk("R3 one beat writes nothing", 16'(empty[0]), 16'h1);
      push(8'h2A);
      push(8'h03); push(8'hBC);
      pop_one(); chk("R3 nibble order a", dout, 16'h00A1);
      pop_one(); chk("R3 nibble order b", dout, 16'h00C3);
   endtask

   task automatic t_mode16();
      mode = 2'b10;
      push(8'h11);
      chk("R4 half word writes nothing", 16'(empty), 16'h3);
      push(8'h22);
      chk("R4 both queues written", 16'(empty), 16'h0);
      push(8'h33); push(8'h44);
      pop_one(); chk("R4 word0", dout, 16'h2211);
      pop_one(); chk("R4 word1", dout, 16'h4433);
      chk("R4 both drained", 16'(empty), 16'h3);
   endtask

   task automatic t_capacity();
      mode = 2'b01;
      for (int i = 0; i < 16; i++) begin
         chk("R8 not full early", 16'(full[0]), 16'h0);
         push(8'(i));
      end
      chk("R5 full after 16", 16'(full[0]), 16'h1);
      chk("R5 ready low", 16'(px_ready), 16'h0);
      px_valid = 1'b1; px_data = 8'hEE;
      @(posedge clk); #1;
      @(posedge clk); #1;
      px_valid = 1'b0;
      chk("R5 still full", 16'(full[0]), 16'h1);
      for (int i = 0; i < 16; i++) begin
         pop_one();
         chk("R5 drain order", dout, 16'(i));
      end
      chk("R5 nothing extra stored", 16'(empty[0]), 16'h1);
   endtask

   task automatic t_simul();
      mode = 2'b01;
      push(8'h10); push(8'h20); push(8'h30);
      px_valid = 1'b1; px_data = 8'h40; pop = 1'b1;
      @(posedge clk); #1;
      px_valid = 1'b0; pop = 1'b0;
      chk("R6 pop during write", dout, 16'h0010);
      pop_one(); chk("R6 order a", dout, 16'h0020);
      pop_one(); chk("R6 order b", dout, 16'h0030);
      pop_one(); chk("R6 new entry", dout, 16'h0040);
      chk("R6 drained", 16'(empty[0]), 16'h1);
   endtask

   task automatic t_underflow();
      mode = 2'b01;
      pop_one();
      chk("R7 dout held", dout, 16'h0040);
      chk("R7 flag set", 16'(underflow), 16'h1);
      push(8'h55);
      pop_one();
      chk("R7 later pop data", dout, 16'h0055);
      chk("R7 flag sticky", 16'(underflow), 16'h1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;
      t_reset();
      t_mode8();
      t_mode4();
      t_mode16();
      t_capacity();
      t_simul();
      t_underflow();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #1000000;
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule